// File: doc/BRIEF.md
# Scanning ADC Sequencer Register Block

This block is the byte-wide register front end of a 32-channel analog-input sequencer. A host sets a first and a last channel number, a range/gain code with a choice of gap between conversions, the sample FIFO mode and an end-of-scan interrupt enable. A write of any value to the start offset, or a one-cycle pulse on the external tick input, launches either one conversion of the first channel or, with scanning on, one pass over consecutive channels from the first to the last. Channel numbers count upwards and wrap from 31 to 0.

The converter is represented by a channel-select output and a 16-bit sample input that the block captures a fixed number of cycles after each conversion starts. Each result goes into a sample FIFO. The host reads a result as the low byte at offset 0 and then the high byte at offset 1, and the read of offset 1 removes the entry. Busy, current channel, FIFO flags, interrupt state and a settling-wait flag can all be read on the bus. After reset the status registers hold fixed values, so a driver can use them to detect the block.

Top module: `adc_scan_regs`

## Requirements
- R1: After reset, offset 7 reads 0x80, offset 8 reads 0x60, offset 9 reads 0x00, offset 11 reads 0x00, offsets 2 and 3 read 0x00, and the irq output is low.
- R2: Offsets 2 (first channel) and 3 (last channel) keep only bits 4:0 and read back with bits 7:5 zero, so a write of 0x80 reads back 0x00 and a write of 0xFF reads back 0x1F.
- R3: A write to offset 0 or a tick pulse, while idle with scanning off (offset 7 bit 2 clear), makes one conversion of the first channel. Offset 8 bit 7 (busy) is high for exactly CONV_CYC cycles, and the result equals the sample input seen for that channel.
- R4: With scanning on, results enter the FIFO for channels first, first+1, ... up to last, counting modulo 32. That is ((last-first) mod 32)+1 results in that order.
- R5: Offset 11 bits 5:4 select the gap between conversions inside a scan: 0, 1, 2 and 3 give 20, 15, 10 and 5 microseconds of clock cycles. A scan of N channels is busy for N*CONV_CYC + (N-1)*gap cycles.
- R6: Offset 0 reads bits 7:0 of the oldest result and offset 1 reads bits 15:8. A bus read of offset 1 removes that result. Offset 8 bits 4:0 show the current channel.
- R7: Offset 7 read gives bit 7 empty, bit 6 half-full (at least FIFO_DEPTH/2 entries), bit 5 full, bit 4 overflow, and bits 3 and 2 echo FIFO enable and scan enable. A write to offset 7 with bit 1 set empties the FIFO and clears the overflow flag.
- R8: With the FIFO enabled (offset 7 bit 3), a result that arrives while the FIFO is full is dropped and sets the overflow flag. The flag stays set until a FIFO reset, and the stored results stay intact.
- R9: With the FIFO disabled, each new result replaces the stored one, so at most one result is held.
- R10: Offset 11 reads bits 3:0 as last written. Bit 7 is high for SETTLE_CYC cycles after each write to offset 11 and low otherwise.
- R11: With offset 9 bit 7 set, the end of a scan or single conversion sets a pending flag that reads as offset 9 bit 7 and drives irq. A write to offset 8 with bit 3 set clears it. With the enable clear, no flag is raised.
- R12: A start write or tick while busy is ignored: the running operation keeps its timing and no extra conversion takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (side effect only at offset 1) |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| ext_tick | input | 1 | External trigger pulse, acts like a start write |
| conv_chan | output | 5 | Channel presented to the converter |
| conv_data | input | 16 | Converter sample for conv_chan |
| irq | output | 1 | End-of-scan interrupt request |

## Verification
On every cycle the assertions check that the channel registers read back only five bits, that a start from idle makes the block busy, that overflow stays set until a FIFO reset, that the FIFO count stays in range, that a pending interrupt appears only on the cycle a conversion sequence ends, and that a configuration write raises the settling flag. Channel order with wrap-around, scan duration for each gap code, sample values, FIFO flag combinations, the one-deep mode with the FIFO disabled, and ignored starts can only be shown by the bench scenarios. These measure busy time and drain the FIFO against values the bench computes itself.

// File: rtl/adc_scan_regs.sv
module adc_scan_regs #(
  parameter int CLK_HZ     = 1_000_000,
  parameter int CONV_CYC   = 4,
  parameter int SETTLE_CYC = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        ext_tick,
  output logic [4:0]  conv_chan,
  input  logic [15:0] conv_data,
  output logic        irq
);
  localparam int US_CYC = CLK_HZ / 1_000_000;
  localparam int AW     = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int TW     = $clog2(20 * US_CYC + CONV_CYC + 1);
  localparam int SW     = $clog2(SETTLE_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_GAP} st_t;

  st_t            st;
  logic [TW-1:0]  tmr, gap_len;
  logic [4:0]     cur_chan, lo_q, hi_q;
  logic [5:0]     cfg_q;
  logic           fen_q, sen_q, ien_q, pend_q, ovf_q;
  logic [SW-1:0]  settle_cnt;
  logic [15:0]    mem [FIFO_DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [AW:0]    fcount;

  wire busy      = (st != S_IDLE);
  wire start_req = (wr_en && addr == 4'd0) || ext_tick;
  wire conv_done = (st == S_CONV) && (tmr == '0);
  wire last_chan = !sen_q || (cur_chan == hi_q);
  wire settling  = (settle_cnt != '0);
  wire empty     = (fcount == '0);
  wire full      = (fcount == (AW+1)'(FIFO_DEPTH));
  wire half      = (fcount >= (AW+1)'(FIFO_DEPTH / 2));
  wire fifo_clr  = wr_en && addr == 4'd7 && wdata[1];
  wire pop       = rd_en && addr == 4'd1 && !empty;
  wire push      = conv_done;
  wire store     = push && (!fen_q || !full);

  assign conv_chan = cur_chan;
  assign irq       = pend_q && ien_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    case (cfg_q[5:4])
      2'd0:    gap_len = TW'(20 * US_CYC - 1);
      2'd1:    gap_len = TW'(15 * US_CYC - 1);
      2'd2:    gap_len = TW'(10 * US_CYC - 1);
      default: gap_len = TW'(5 * US_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmr      <= '0;
      cur_chan <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_req) begin
          st       <= S_CONV;
          tmr      <= TW'(CONV_CYC - 1);
          cur_chan <= lo_q;
        end
        S_CONV: if (tmr != '0) tmr <= tmr - 1'b1;
          else if (last_chan) st <= S_IDLE;
          else begin
            cur_chan <= cur_chan + 1'b1;
            st       <= S_GAP;
            tmr      <= gap_len;
          end
        default: if (tmr != '0) tmr <= tmr - 1'b1;
          else begin
            st  <= S_CONV;
            tmr <= TW'(CONV_CYC - 1);
          end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0; hi_q <= '0; cfg_q <= '0;
      fen_q <= 1'b0; sen_q <= 1'b0; ien_q <= 1'b0; pend_q <= 1'b0;
      settle_cnt <= '0;
    end else begin
      if (wr_en && addr == 4'd2) lo_q <= wdata[4:0];
      if (wr_en && addr == 4'd3) hi_q <= wdata[4:0];
      if (wr_en && addr == 4'd7) begin
        fen_q <= wdata[3];
        sen_q <= wdata[2];
      end
      if (wr_en && addr == 4'd9) ien_q <= wdata[7];
      if (wr_en && addr == 4'd11) begin
        cfg_q      <= wdata[5:0];
        settle_cnt <= SW'(SETTLE_CYC);
      end else if (settling) settle_cnt <= settle_cnt - 1'b1;
      if (conv_done && last_chan && ien_q) pend_q <= 1'b1;
      else if ((wr_en && addr == 4'd8 && wdata[3]) || (wr_en && addr == 4'd9 && !wdata[7]))
        pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fifo_clr) begin
      wr_ptr <= '0; rd_ptr <= '0; fcount <= '0; ovf_q <= 1'b0;
    end else if (push && !fen_q) begin
      rd_ptr <= wr_ptr;
      wr_ptr <= nxt(wr_ptr);
      fcount <= (AW+1)'(1);
    end else begin
      if (pop) rd_ptr <= nxt(rd_ptr);
      if (store) begin
        wr_ptr <= nxt(wr_ptr);
        fcount <= fcount + 1'b1 - (AW+1)'(pop);
      end else begin
        fcount <= fcount - (AW+1)'(pop);
        if (push) ovf_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) if (store) mem[wr_ptr] <= conv_data;

  always_comb begin
    case (addr)
      4'd0:    rdata = mem[rd_ptr][7:0];
      4'd1:    rdata = mem[rd_ptr][15:8];
      4'd2:    rdata = {3'b000, lo_q};
      4'd3:    rdata = {3'b000, hi_q};
      4'd7:    rdata = {empty, half, full, ovf_q, fen_q, sen_q, 2'b00};
      4'd8:    rdata = {busy, 2'b11, cur_chan};
      4'd9:    rdata = {pend_q, 7'b0};
      4'd11:   rdata = {settling, 3'b000, cfg_q[3:0]};
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/adc_scan_regs_chk.sv
module adc_scan_regs_chk #(
  parameter int DEPTH = 16,
  localparam int CW = ((DEPTH > 1) ? $clog2(DEPTH) : 1) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [3:0]    addr,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic          busy,
  input logic          ovf,
  input logic [CW-1:0] fcount,
  input logic          pend,
  input logic          settling
);
  p_chan_five_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd2 || addr == 4'd3) |-> rdata[7:5] == 3'b000);

  p_start_goes_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && addr == 4'd0) |=> busy);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(wr_en && addr == 4'd7 && wdata[1])) |=> ovf);

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fcount <= CW'(DEPTH));

  p_pend_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $fell(busy));

  p_settle_after_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd11) |=> settling);
endmodule

bind adc_scan_regs adc_scan_regs_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .busy(busy), .ovf(ovf_q), .fcount(fcount), .pend(pend_q),
  .settling(settling)
);

// File: tb/adc_scan_regs_tb.sv
module adc_scan_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CONV = 4;
  localparam int SETTLE = 8;
  localparam int DEPTH = 16;
  localparam int US = 1;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, ext_tick = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [4:0] conv_chan;
  logic [15:0] conv_data;
  logic irq;
  int n_run = 0, n_fail = 0;
  logic [7:0] d;
  int m;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] smp(input int ch);
    return 16'((ch * 2113) ^ 16'h5A3C);
  endfunction
  assign conv_data = smp(int'(conv_chan));

  adc_scan_regs #(.CLK_HZ(1_000_000), .CONV_CYC(CONV), .SETTLE_CYC(SETTLE),
                  .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_tick(ext_tick), .conv_chan(conv_chan),
    .conv_data(conv_data), .irq(irq));

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] v);
    wr_en = 1; addr = a; wdata = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] v);
    addr = a; rd_en = 0; #1 v = rdata;
  endtask

  task automatic pop_sample(output logic [15:0] v);
    logic [7:0] lo, hi;
    peek(4'd0, lo); peek(4'd1, hi);
    v = {hi, lo};
    rd_en = 1; @(negedge clk); rd_en = 0;
  endtask

  task automatic poll(output int cyc);
    logic [7:0] s;
    cyc = 0;
    peek(4'd8, s);
    while (s[7] && cyc < 100000) begin
      @(negedge clk); cyc++; peek(4'd8, s);
    end
  endtask

  task automatic tick_pulse();
    ext_tick = 1; @(negedge clk); ext_tick = 0;
  endtask

  task automatic run_scan(input int lo, input int hi, input int gsel, input logic [7:0] ctrl);
    logic [15:0] v;
    logic [7:0] s;
    int n, g, t;
    bus_wr(4'd7, ctrl | 8'h02);
    bus_wr(4'd2, 8'(lo)); bus_wr(4'd3, 8'(hi));
    bus_wr(4'd11, 8'(gsel << 4));
    bus_wr(4'd0, 8'h5A);
    poll(t);
    n = ctrl[2] ? (((hi - lo) & 31) + 1) : 1;
    g = US * ((gsel == 0) ? 20 : (gsel == 1) ? 15 : (gsel == 2) ? 10 : 5);
    chk($sformatf("R5 busy time lo=%0d hi=%0d g=%0d", lo, hi, gsel), t, n*CONV + (n-1)*g);
    for (int i = 0; i < n; i++) begin
      pop_sample(v);
      chk($sformatf("R4 sample %0d of scan %0d..%0d", i, lo, hi), v, smp((lo + i) & 31));
    end
    peek(4'd7, s);
    chk("R6 FIFO empty after drain", s[7], 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++; n_run++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    peek(4'd7, d);  chk("R1 fifo status", d, 8'h80);
    peek(4'd8, d);  chk("R1 ai status", d, 8'h60);
    peek(4'd9, d);  chk("R1 int reg", d, 8'h00);
    peek(4'd11, d); chk("R1 readback", d, 8'h00);
    peek(4'd2, d);  chk("R1 first chan", d, 8'h00);
    peek(4'd3, d);  chk("R1 last chan", d, 8'h00);
    chk("R1 irq", irq, 0);

    bus_wr(4'd2, 8'h80); bus_wr(4'd3, 8'hFF);
    peek(4'd2, d); chk("R2 first chan 0x80", d, 8'h00);
    peek(4'd3, d); chk("R2 last chan 0xFF", d, 8'h1F);

    bus_wr(4'd11, 8'h3D);
    peek(4'd11, d); chk("R10 settling at write", d, 8'h8D);
    repeat (SETTLE - 1) @(negedge clk);
    peek(4'd11, d); chk("R10 settling last cycle", d, 8'h8D);
    @(negedge clk);
    peek(4'd11, d); chk("R10 settled", d, 8'h0D);

    for (int ch = 0; ch < 32; ch++) begin
      bus_wr(4'd7, 8'h0A);
      bus_wr(4'd2, 8'(ch)); bus_wr(4'd3, 8'((ch + 7) & 31));
      bus_wr(4'd0, 8'h00);
      peek(4'd8, d); chk("R6 current channel", d, 8'hE0 | 8'(ch));
      poll(m); chk("R3 single busy time", m, CONV);
      pop_sample(v); chk("R3 single sample", v, smp(ch));
      peek(4'd7, d); chk("R3 only one result", d, 8'h88);
    end

    for (int gs = 0; gs < 4; gs++) begin
      run_scan(0, 3, gs, 8'h0C);
      run_scan(5, 5, gs, 8'h0C);
      run_scan(29, 2, gs, 8'h0C);
      run_scan(10, 25, gs, 8'h0C);
    end

    bus_wr(4'd7, 8'h0E); bus_wr(4'd2, 8'd0); bus_wr(4'd3, 8'd7);
    bus_wr(4'd11, 8'h30); bus_wr(4'd0, 8'h01); poll(m);
    peek(4'd7, d); chk("R7 half full at 8", d, 8'h4C);
    pop_sample(v);
    peek(4'd7, d); chk("R7 below half", d, 8'h0C);

    bus_wr(4'd7, 8'h0E); bus_wr(4'd3, 8'd17); bus_wr(4'd0, 8'h01); poll(m);
    peek(4'd7, d); chk("R8 full with overflow", d, 8'h7C);
    for (int i = 0; i < DEPTH; i++) begin
      pop_sample(v); chk("R8 kept sample", v, smp(i));
    end
    peek(4'd7, d); chk("R8 overflow sticky", d, 8'h9C);
    bus_wr(4'd7, 8'h0E);
    peek(4'd7, d); chk("R7 reset clears overflow", d, 8'h8C);

    bus_wr(4'd7, 8'h06); bus_wr(4'd2, 8'd3); bus_wr(4'd3, 8'd6);
    bus_wr(4'd0, 8'h01); poll(m);
    peek(4'd7, d); chk("R9 one held, FIFO off", d, 8'h04);
    pop_sample(v); chk("R9 newest result", v, smp(6));
    peek(4'd7, d); chk("R9 empty after read", d, 8'h84);

    bus_wr(4'd7, 8'h0A); bus_wr(4'd2, 8'd9);
    tick_pulse(); poll(m); chk("R3 tick busy time", m, CONV);
    pop_sample(v); chk("R3 tick sample", v, smp(9));

    bus_wr(4'd0, 8'h01); bus_wr(4'd0, 8'h01); tick_pulse(); poll(m);
    chk("R12 timing unchanged", m, CONV - 2);
    pop_sample(v); chk("R12 sample", v, smp(9));
    peek(4'd7, d); chk("R12 no extra conversion", d, 8'h88);

    bus_wr(4'd9, 8'h80); bus_wr(4'd0, 8'h01); poll(m);
    chk("R11 irq raised", irq, 1);
    peek(4'd9, d); chk("R11 pending bit", d, 8'h80);
    bus_wr(4'd8, 8'h08);
    chk("R11 irq cleared", irq, 0);
    peek(4'd9, d); chk("R11 pending cleared", d, 8'h00);
    bus_wr(4'd9, 8'h00); bus_wr(4'd0, 8'h01); poll(m);
    chk("R11 no irq when disabled", irq, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule